// File: doc/BRIEF.md
# Thread Register Partition Allocator

This block decides whether a thread block can be admitted onto one multithreaded multiprocessor, based on how much of the shared 32-bit register file the block needs. The register file is split into eight lane banks of 1024 rows each, for 8192 registers in total. Threads are grouped 32 to a warp. Inside a warp, each lane serves four consecutive threads. A block therefore takes the same row range on every lane. The number of rows it takes is its per-lane slot count multiplied by its registers per thread.

A request carries a thread count and a per-thread register demand. The block answers in the same cycle. It either grants the request, returning a base row and a table slot, or it rejects it. A release port returns a resident block's rows to the pool. The cycle after a release is spent folding the freed space back into the counters. During that cycle `busy` is high and requests are held off. A separate combinational port turns a (table slot, thread ID, register index) triple into the physical lane and row.

Top module: `reg_partition_alloc`

## Requirements
- R1: A request presented while `req_ready` is high gets exactly one of `grant` or `reject` in that same cycle. On a grant, `grant_base` is the lowest row at which the block's rows fit without overlapping any resident block, and `grant_id` is the lowest unused table slot.
- R2: A block with T threads takes S rows per thread on each lane. S = 4*(T/32) + min(T mod 32, 4), and the row demand is S times the registers per thread. The request is rejected if no contiguous free range of that many rows exists below row 1024. It is also rejected if T times the registers per thread exceeds eight times the free rows per lane. At 32 registers per thread, one 256-thread block fills every lane.
- R3: The slot counts S of all resident blocks may sum to at most 64 per lane. A request that would exceed 64 is rejected. A request that reaches exactly 64 is accepted.
- R4: A thread count of 0 or above 512 is rejected, with `reg_err` low, and leaves the allocation unchanged.
- R5: A register demand of 0 or above 64 is rejected with `reg_err` high in the same cycle.
- R6: At most 8 blocks are resident. A ninth request is rejected even when rows are free.
- R7: A release of a resident slot sets `busy` high for exactly the next cycle, with `req_ready` low during that cycle. After that, the freed rows can be reused, and they merge with neighbouring free rows into one range.
- R8: The mapping port gives lane = (tid / 4) mod 8. It gives row = base + (4*(tid/32) + tid mod 4) * regs + reg_index, where base and regs are those of the addressed slot.
- R9: A release of a slot that is not resident does nothing. `busy` stays low.
- R10: After reset, no block is resident, `req_ready` is high, and `busy`, `grant` and `reject` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Admission request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_threads | input | 10 | Threads in the block |
| req_regs | input | 7 | Registers needed per thread |
| grant | output | 1 | Request admitted |
| reject | output | 1 | Request refused |
| reg_err | output | 1 | Register demand out of range |
| grant_base | output | 10 | First row of the admitted block |
| grant_id | output | 3 | Table slot of the admitted block |
| rel_valid | input | 1 | Release request |
| rel_id | input | 3 | Slot to release |
| busy | output | 1 | Freed space being folded back |
| map_id | input | 3 | Slot for address mapping |
| map_tid | input | 9 | Thread ID inside the block |
| map_reg | input | 6 | Register index inside the thread |
| map_lane | output | 3 | Lane bank of the register |
| map_row | output | 10 | Row in that lane bank |

## Verification
The hardest case to reach is the merge of two adjacent free ranges. It needs two neighbouring blocks released, followed by a request that fits only the combined range and neither piece alone. The stimulus builds a layout with gaps and releases two adjacent blocks. It then asks for 140 rows, which is more than either freed piece of 128 or 16 rows. The lane-slot limit is pushed to exactly 64 and then one past it. The table is filled to its eighth entry using single-row blocks placed into a small leftover gap.

// File: rtl/reg_partition_alloc.sv
module reg_partition_alloc #(
  parameter int NUM_LANES    = 8,
  parameter int LANE_ROWS    = 1024,
  parameter int WARP         = 32,
  parameter int MAX_BLOCKS   = 8,
  parameter int MAX_THREADS  = 512,
  parameter int MAX_REGS     = 64,
  parameter int LANE_THREADS = 64,
  localparam int TW = $clog2(MAX_THREADS) + 1,
  localparam int XW = $clog2(MAX_THREADS),
  localparam int RW = $clog2(MAX_REGS) + 1,
  localparam int AW = $clog2(LANE_ROWS),
  localparam int IW = $clog2(MAX_BLOCKS),
  localparam int LW = $clog2(NUM_LANES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [TW-1:0] req_threads,
  input  logic [RW-1:0] req_regs,
  output logic          grant,
  output logic          reject,
  output logic          reg_err,
  output logic [AW-1:0] grant_base,
  output logic [IW-1:0] grant_id,
  input  logic          rel_valid,
  input  logic [IW-1:0] rel_id,
  output logic          busy,
  input  logic [IW-1:0] map_id,
  input  logic [XW-1:0] map_tid,
  input  logic [RW-2:0] map_reg,
  output logic [LW-1:0] map_lane,
  output logic [AW-1:0] map_row
);
  localparam int Q  = WARP / NUM_LANES;
  localparam int QB = $clog2(Q);
  localparam int WB = $clog2(WARP);
  localparam int NW = AW + RW + 3;
  localparam int PW = TW + RW + 2;
  localparam int FW = AW + 1;

  logic [MAX_BLOCKS-1:0] vld;
  logic [AW-1:0] base_q [MAX_BLOCKS];
  logic [FW-1:0] size_q [MAX_BLOCKS];
  logic [TW-1:0] slot_q [MAX_BLOCKS];
  logic [RW-1:0] regs_q [MAX_BLOCKS];
  logic [FW-1:0] free_rows;
  logic [TW-1:0] used_slots;
  logic          busy_q;
  logic [FW-1:0] pend_size;
  logic [TW-1:0] pend_slots;

  logic [TW-1:0] n_warps, n_rem, req_slots;
  logic [NW-1:0] need;
  logic [PW-1:0] prod;
  logic          regs_ok, thr_ok, fit_ok, id_ok, lane_ok, pool_ok, ok, fire, rel_fire;
  logic [NW-1:0] fit_at;
  logic [IW-1:0] free_id;
  logic [NW-1:0] ends [MAX_BLOCKS+1];
  logic [MAX_BLOCKS:0] cvld;

  assign n_warps   = req_threads >> WB;
  assign n_rem     = req_threads & TW'(WARP - 1);
  assign req_slots = n_warps * TW'(Q) + ((n_rem > TW'(Q)) ? TW'(Q) : n_rem);
  assign need      = NW'(req_slots) * NW'(req_regs);
  assign prod      = PW'(req_threads) * PW'(req_regs);

  assign regs_ok = (req_regs != '0) && (req_regs <= RW'(MAX_REGS));
  assign thr_ok  = (req_threads != '0) && (req_threads <= TW'(MAX_THREADS));
  assign lane_ok = (TW'(used_slots + req_slots) <= TW'(LANE_THREADS)) && (req_slots <= TW'(LANE_THREADS));
  assign pool_ok = prod <= PW'(free_rows) * PW'(NUM_LANES);

  assign ends[0] = '0;
  assign cvld[0] = 1'b1;
  for (genvar g = 0; g < MAX_BLOCKS; g++) begin : g_ends
    assign ends[g+1] = NW'(base_q[g]) + NW'(size_q[g]);
    assign cvld[g+1] = vld[g];
  end

  always_comb begin
    logic [NW-1:0] cand;
    logic          good;
    fit_ok = 1'b0;
    fit_at = '0;
    for (int k = 0; k <= MAX_BLOCKS; k++) begin
      cand = ends[k];
      good = cvld[k] && (cand + need <= NW'(LANE_ROWS));
      for (int j = 0; j < MAX_BLOCKS; j++)
        if (vld[j] && (cand < ends[j+1]) && (cand + need > NW'(base_q[j])))
          good = 1'b0;
      if (good && (!fit_ok || cand < fit_at)) begin
        fit_ok = 1'b1;
        fit_at = cand;
      end
    end
  end

  always_comb begin
    free_id = '0;
    id_ok   = 1'b0;
    for (int i = MAX_BLOCKS - 1; i >= 0; i--)
      if (!vld[i]) begin
        free_id = IW'(i);
        id_ok   = 1'b1;
      end
  end

  assign req_ready  = !busy_q && !rel_valid;
  assign fire       = req_valid && req_ready;
  assign ok         = regs_ok && thr_ok && lane_ok && pool_ok && fit_ok && id_ok;
  assign grant      = fire && ok;
  assign reject     = fire && !ok;
  assign reg_err    = fire && !regs_ok;
  assign grant_base = fit_at[AW-1:0];
  assign grant_id   = free_id;
  assign rel_fire   = rel_valid && !busy_q && vld[rel_id];
  assign busy       = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld        <= '0;
      free_rows  <= FW'(LANE_ROWS);
      used_slots <= '0;
      busy_q     <= 1'b0;
      pend_size  <= '0;
      pend_slots <= '0;
      for (int i = 0; i < MAX_BLOCKS; i++) begin
        base_q[i] <= '0;
        size_q[i] <= '0;
        slot_q[i] <= '0;
        regs_q[i] <= '0;
      end
    end else begin
      if (grant) begin
        vld[free_id]    <= 1'b1;
        base_q[free_id] <= fit_at[AW-1:0];
        size_q[free_id] <= need[FW-1:0];
        slot_q[free_id] <= req_slots;
        regs_q[free_id] <= req_regs;
        free_rows       <= free_rows - need[FW-1:0];
        used_slots      <= used_slots + req_slots;
      end
      if (rel_fire) begin
        vld[rel_id] <= 1'b0;
        busy_q      <= 1'b1;
        pend_size   <= size_q[rel_id];
        pend_slots  <= slot_q[rel_id];
      end
      if (busy_q) begin
        busy_q     <= 1'b0;
        free_rows  <= free_rows + pend_size;
        used_slots <= used_slots - pend_slots;
      end
    end
  end

  logic [NW-1:0] map_slot, map_full;
  assign map_slot = NW'(map_tid >> WB) * NW'(Q) + NW'(map_tid[QB-1:0]);
  assign map_full = NW'(base_q[map_id]) + map_slot * NW'(regs_q[map_id]) + NW'(map_reg);
  assign map_lane = map_tid[QB +: LW];
  assign map_row  = map_full[AW-1:0];
endmodule

// File: rtl/alloc_checker.sv
module alloc_checker #(
  parameter int TW = 10,
  parameter int MAX_THREADS = 512
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [TW-1:0] req_threads,
  input logic          grant,
  input logic          reject,
  input logic          reg_err,
  input logic          busy,
  input logic          rel_valid
);
  assert_one_outcome_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && reject));
  assert_grant_handshake_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (grant || reject) |-> (req_valid && req_ready));
  assert_bad_threads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_threads == '0 || req_threads > TW'(MAX_THREADS))) |-> reject);
  assert_err_rejects_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_err |-> reject);
  assert_busy_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(rel_valid));
  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  assert_busy_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
endmodule

bind reg_partition_alloc alloc_checker #(.TW(TW), .MAX_THREADS(MAX_THREADS)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_threads(req_threads), .grant(grant), .reject(reject), .reg_err(reg_err),
  .busy(busy), .rel_valid(rel_valid)
);

// File: tb/reg_partition_alloc_tb_top.sv
`timescale 1ns/1ps
module reg_partition_alloc_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [9:0] req_threads = '0;
  logic [6:0] req_regs = '0;
  logic grant, reject, reg_err, busy;
  logic [9:0] grant_base;
  logic [2:0] grant_id;
  logic rel_valid = 1'b0;
  logic [2:0] rel_id = '0;
  logic [2:0] map_id = '0;
  logic [8:0] map_tid = '0;
  logic [5:0] map_reg = '0;
  logic [2:0] map_lane;
  logic [9:0] map_row;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [14:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  reg_partition_alloc dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_threads(req_threads), .req_regs(req_regs), .grant(grant), .reject(reject),
    .reg_err(reg_err), .grant_base(grant_base), .grant_id(grant_id),
    .rel_valid(rel_valid), .rel_id(rel_id), .busy(busy), .map_id(map_id),
    .map_tid(map_tid), .map_reg(map_reg), .map_lane(map_lane), .map_row(map_row));

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (req_valid && req_ready) begin
      logic [14:0] e;
      logic [14:0] g;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      g = {grant, reg_err, grant ? grant_base : 10'd0, grant ? grant_id : 3'd0};
      check(t, 32'(g), 32'(e));
      check({t, " reject"}, 32'(reject), 32'(!e[14]));
    end
  end

  task automatic req(input int t, input int r, input bit g, input bit er,
                     input int base, input int id, input string tag);
    @(negedge clk);
    req_threads = 10'(t);
    req_regs = 7'(r);
    req_valid = 1'b1;
    exp_q.push_back({g, er, g ? 10'(base) : 10'd0, g ? 3'(id) : 3'd0});
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic release_blk(input int id, input bit exp_busy, input string tag);
    @(negedge clk);
    rel_valid = 1'b1;
    rel_id = 3'(id);
    @(negedge clk);
    rel_valid = 1'b0;
    #1;
    check({tag, " busy"}, 32'(busy), 32'(exp_busy));
    check({tag, " ready"}, 32'(req_ready), 32'(!exp_busy));
    @(negedge clk);
    #1;
    check({tag, " busy clear"}, 32'(busy), 32'd0);
  endtask

  task automatic map_chk(input int id, input int tid, input int rg, input int lane,
                         input int row, input string tag);
    @(negedge clk);
    map_id = 3'(id);
    map_tid = 9'(tid);
    map_reg = 6'(rg);
    #1;
    check({tag, " lane"}, 32'(map_lane), 32'(lane));
    check({tag, " row"}, 32'(map_row), 32'(row));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R10 ready", 32'(req_ready), 32'd1);
    check("R10 busy", 32'(busy), 32'd0);
    check("R10 grant", 32'(grant), 32'd0);
    check("R10 reject", 32'(reject), 32'd0);

    req(256, 32, 1, 0, 0, 0, "R2 full lane block");
    req(1, 1, 0, 0, 0, 0, "R2 no rows left");
    release_blk(0, 1, "R7 release");

    req(64, 16, 1, 0, 0, 0, "R1 first");
    req(32, 8, 1, 0, 128, 1, "R1 second");
    req(100, 10, 1, 0, 160, 2, "R1 third");

    map_chk(2, 37, 3, 1, 213, "R8 mid");
    map_chk(2, 99, 9, 0, 319, "R8 last row");
    map_chk(0, 0, 0, 0, 0, "R8 origin");
    map_chk(0, 63, 15, 7, 127, "R8 lane7");

    release_blk(1, 1, "R7 release mid");
    req(8, 4, 1, 0, 128, 1, "R7 reuse gap");
    req(5, 6, 1, 0, 320, 3, "R1 first fit skips small gap");
    release_blk(0, 1, "R7 release low");
    release_blk(1, 1, "R7 release neighbour");
    req(98, 10, 1, 0, 0, 0, "R7 merged range");

    req(10, 0, 0, 1, 0, 0, "R5 zero regs");
    req(10, 65, 0, 1, 0, 0, "R5 regs too high");
    req(513, 1, 0, 0, 0, 0, "R4 too many threads");
    req(0, 4, 0, 0, 0, 0, "R4 zero threads");

    req(512, 1, 0, 0, 0, 0, "R3 lane over");
    req(226, 1, 1, 0, 344, 1, "R3 lane exactly full R4 state kept");
    req(1, 1, 0, 0, 0, 0, "R3 lane full");
    release_blk(1, 1, "R7 release full");

    req(1, 1, 1, 0, 140, 1, "R6 fill a");
    req(1, 1, 1, 0, 141, 4, "R6 fill b");
    req(1, 1, 1, 0, 142, 5, "R6 fill c");
    req(1, 1, 1, 0, 143, 6, "R6 fill d");
    req(1, 1, 1, 0, 144, 7, "R6 fill e");
    req(1, 1, 0, 0, 0, 0, "R6 table full");

    release_blk(1, 1, "R7 release one");
    release_blk(1, 0, "R9 idle release");
    req(1, 1, 1, 0, 140, 1, "R9 slot reused once");

    repeat (3) @(negedge clk);
    check("R1 scoreboard drained", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule